// File: doc/BRIEF.md
# Cascaded Load Clock Divider

This block derives two slower clocks from a synthesized pixel clock. The first stage is a prescaler whose modulus comes from a 3-bit encoded select. It produces the load clock `load_o`. The second stage advances once per load clock period and divides it again by any integer from 1 to 512, producing `ld_n2_o`. Both moduli come from register fields that the surrounding logic holds on the inputs. A suppress bit parks the load clock low and freezes the second stage.

Everything runs in the pixel clock domain. The second stage counts on the pixel clock edge where the load clock rises, so the two outputs stay phase aligned and no derived clock drives a flop. Both outputs come from registers. A new setting is only taken at the terminal count of the stage it belongs to, so a change made part way through a period never produces a shortened pulse.

Top module: `load_div_chain`

## Requirements
- R1: `sel_i` codes 0, 1, 2, 3, 4 and 5 give a first-stage modulus of 3, 4, 5, 6, 8 and 10 pixel clocks respectively.
- R2: The unused `sel_i` codes 6 and 7 give a first-stage modulus of 4.
- R3: For an even modulus m, `load_o` is high for m/2 cycles and low for m/2 cycles. For an odd m, it is high for (m+1)/2 cycles and low for (m-1)/2 cycles. After reset is released, or after suppress is released, `load_o` goes high on the first clock edge.
- R4: The second-stage modulus is N = `n2_i` + 1, where the 9-bit field value 0..511 maps to 1..512. For N >= 2, `ld_n2_o` is high for ceil(N/2) load periods and low for floor(N/2) load periods.
- R5: With `n2_i` = 0 (N = 1), `ld_n2_o` follows `load_o` exactly.
- R6: A change on `sel_i` or `n2_i` takes effect only at the terminal count of its stage. The period in progress completes with its old high and low times.
- R7: While `suppress_i` is high, `load_o` is low from the next clock edge and the second-stage counter holds. For N >= 2, `ld_n2_o` keeps its value. On release, `load_o` goes high at the first edge.
- R8: During reset, both `load_o` and `ld_n2_o` are low.
- R9: Every rising edge of `ld_n2_o` falls in the same cycle as a rising edge of `load_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Encoded first-stage modulus select |
| suppress_i | input | 1 | Suppress load clock, freeze second stage |
| n2_i | input | 9 | Second-stage modulus minus one |
| load_o | output | 1 | Load clock |
| ld_n2_o | output | 1 | Load clock divided by n2_i+1 |

## Verification
The bench measures high and low times for every select code, including the two unused codes. A wrong decode or a wrong duty split shows up as a mismatched pulse width. It runs the divide-by-1 bypass and the 512 maximum. A counter that is one bit short, or a bypass that misses, would halve or stretch those periods. It changes both moduli in the middle of a period and expects that period to finish unchanged. A design that loads settings at once would cut the pulse short. It also parks the outputs with suppress and checks that the second stage neither drifts nor misses the first load edge after release.

// File: rtl/lddiv_pkg.sv
package lddiv_pkg;
  localparam int SEL_W = 3;
  localparam int PRE_W = 4;   // holds moduli up to 10
  localparam int N2_W  = 9;   // 1..512

  function automatic logic [PRE_W-1:0] pre_modulus(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    pre_modulus = PRE_W'(3);
      3'd1:    pre_modulus = PRE_W'(4);
      3'd2:    pre_modulus = PRE_W'(5);
      3'd3:    pre_modulus = PRE_W'(6);
      3'd4:    pre_modulus = PRE_W'(8);
      3'd5:    pre_modulus = PRE_W'(10);
      default: pre_modulus = PRE_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/lddiv_prescale.sv
module lddiv_prescale
  import lddiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             suppress_i,
  output logic             load_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d, thr_q, thr_d, m_new;
  logic             load_q, load_d, term;

  assign term   = (cnt_q == '0);
  assign m_new  = pre_modulus(sel_i);
  assign tick_o = term & ~suppress_i;
  assign load_o = load_q;

  always_comb begin
    cnt_d  = cnt_q;
    thr_d  = thr_q;
    load_d = load_q;
    if (suppress_i) begin
      cnt_d  = '0;
      load_d = 1'b0;
    end else if (term) begin
      // down-count from m-1; high while count >= floor(m/2)
      cnt_d  = m_new - PRE_W'(1);
      thr_d  = m_new >> 1;
      load_d = 1'b1;
    end else begin
      cnt_d  = cnt_q - PRE_W'(1);
      load_d = (cnt_d >= thr_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      thr_q  <= '0;
      load_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      thr_q  <= thr_d;
      load_q <= load_d;
    end
  end

  assert_sup_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_i |=> !load_o);
  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PRE_W'(9));
  assert_mod_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!suppress_i && !term) |=> $stable(thr_q));
endmodule

// File: rtl/lddiv_postscale.sv
module lddiv_postscale
  import lddiv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [N2_W-1:0] n2_i,
  output logic            ld_o
);
  logic [N2_W-1:0] cnt_q, cnt_d, thr_q, thr_d;
  logic            out_q, out_d, byp_q, byp_d;
  logic [N2_W:0]   n_full;

  assign n_full = {1'b0, n2_i} + (N2_W+1)'(1);

  always_comb begin
    cnt_d = cnt_q;
    thr_d = thr_q;
    out_d = out_q;
    byp_d = byp_q;
    if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = n2_i;
        thr_d = N2_W'(n_full >> 1);
        out_d = 1'b1;
        byp_d = (n2_i == '0);
      end else begin
        cnt_d = cnt_q - N2_W'(1);
        out_d = (cnt_d >= thr_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      thr_q <= '0;
      out_q <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      thr_q <= thr_d;
      out_q <= out_d;
      byp_q <= byp_d;
    end
  end

  // both mux inputs are registers, select changes only at terminal count
  assign ld_o = byp_q ? load_i : out_q;

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(out_q)));
  assert_mod_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != '0) |=> ($stable(thr_q) && $stable(byp_q)));
endmodule

// File: rtl/load_div_chain.sv
module load_div_chain
  import lddiv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic            suppress_i,
  input  logic [N2_W-1:0] n2_i,
  output logic            load_o,
  output logic            ld_n2_o
);
  logic tick;

  lddiv_prescale u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .suppress_i (suppress_i),
    .load_o     (load_o),
    .tick_o     (tick)
  );

  lddiv_postscale u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .load_i (load_o),
    .n2_i   (n2_i),
    .ld_o   (ld_n2_o)
  );

  assert_edge_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_n2_o) |-> $rose(load_o));
  assert_reset_low_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!load_o && !ld_n2_o));
endmodule

// File: tb/sim_load_div_chain.sv
module sim_load_div_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {sel, n2, load_hi, load_lo, ld_hi, ld_lo}
  localparam logic [51:0] VEC [NVEC] = '{
    {3'd0, 9'd0, 8'd2, 8'd1, 12'd2,  12'd1},
    {3'd1, 9'd2, 8'd2, 8'd2, 12'd8,  12'd4},
    {3'd2, 9'd1, 8'd3, 8'd2, 12'd5,  12'd5},
    {3'd3, 9'd4, 8'd3, 8'd3, 12'd18, 12'd12},
    {3'd4, 9'd3, 8'd4, 8'd4, 12'd16, 12'd16},
    {3'd5, 9'd6, 8'd5, 8'd5, 12'd40, 12'd30},
    {3'd6, 9'd0, 8'd2, 8'd2, 12'd2,  12'd2},
    {3'd7, 9'd1, 8'd2, 8'd2, 12'd4,  12'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd1;
  logic       sup = 1'b0;
  logic [8:0] n2 = 9'd0;
  logic       load, ld;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_div_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .suppress_i(sup),
    .n2_i(n2), .load_o(load), .ld_n2_o(ld)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ld_rise();
    @(negedge clk);
    while (ld !== 1'b0) @(negedge clk);
    while (ld !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_load_rise();
    @(negedge clk);
    while (load !== 1'b0) @(negedge clk);
    while (load !== 1'b1) @(negedge clk);
  endtask

  // called on the first high sample; returns on the next first high sample
  task automatic meas_ld(output int hi, output int lo);
    hi = 0; lo = 0;
    while (ld === 1'b1) begin hi++; @(negedge clk); end
    while (ld === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic meas_load(output int hi, output int lo);
    hi = 0; lo = 0;
    while (load === 1'b1) begin hi++; @(negedge clk); end
    while (load === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int hi, lo, v;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 load in reset", int'(load), 0);
    check("R8 ld_n2 in reset", int'(ld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 load high at first edge after reset", int'(load), 1);

    // R1 R2 R3 R4 R5 R9: table walk
    for (int i = 0; i < NVEC; i++) begin
      sel = VEC[i][51:49];
      n2  = VEC[i][48:40];
      wait_ld_rise();
      check($sformatf("R9 load rises with ld_n2 vec%0d", i), int'(load), 1);
      meas_ld(hi, lo);
      check($sformatf("R4 R5 ld_n2 high vec%0d", i), hi, int'(VEC[i][23:12]));
      check($sformatf("R4 R5 ld_n2 low vec%0d", i), lo, int'(VEC[i][11:0]));
      meas_load(hi, lo);
      check($sformatf("R1 R2 R3 load high vec%0d", i), hi, int'(VEC[i][39:32]));
      check($sformatf("R1 R2 R3 load low vec%0d", i), lo, int'(VEC[i][31:24]));
    end

    // R4: maximum modulus 512 with divide-by-3
    sel = 3'd0; n2 = 9'd511;
    wait_ld_rise();
    meas_ld(hi, lo);
    check("R4 ld_n2 high N=512", hi, 768);
    check("R4 ld_n2 low N=512", lo, 768);

    // R6: first-stage change mid-period
    sel = 3'd5; n2 = 9'd0;
    wait_load_rise();
    wait_load_rise();
    sel = 3'd0;
    meas_load(hi, lo);
    check("R6 old load high kept", hi, 5);
    check("R6 old load low kept", lo, 5);
    meas_load(hi, lo);
    check("R6 new load high", hi, 2);
    check("R6 new load low", lo, 1);

    // R6: second-stage change mid-period
    sel = 3'd0; n2 = 9'd3;
    wait_ld_rise();
    wait_ld_rise();
    n2 = 9'd1;
    meas_ld(hi, lo);
    check("R6 old ld_n2 high kept", hi, 6);
    check("R6 old ld_n2 low kept", lo, 6);
    meas_ld(hi, lo);
    check("R6 new ld_n2 high", hi, 3);
    check("R6 new ld_n2 low", lo, 3);

    // R7: suppress
    sel = 3'd1; n2 = 9'd3;
    wait_ld_rise();
    wait_ld_rise();
    sup = 1'b1;
    @(negedge clk);
    v = int'(ld);
    check("R7 ld_n2 high when suppressed", v, 1);
    begin
      int bad_l = 0, bad_n = 0;
      for (int k = 0; k < 40; k++) begin
        if (load !== 1'b0) bad_l++;
        if (int'(ld) != v) bad_n++;
        @(negedge clk);
      end
      check("R7 load low while suppressed", bad_l, 0);
      check("R7 ld_n2 held while suppressed", bad_n, 0);
    end
    sup = 1'b0;
    @(negedge clk);
    check("R7 load high at first edge after release", int'(load), 1);
    check("R7 ld_n2 still held after release", int'(ld), v);

    summary();
    $finish;
  end
endmodule